// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers level-sensitive interrupt status from the chip's security checkers: the peripheral protection controllers, the memory protection controllers and the expansion security controllers. It places these levels at fixed, sparse positions in three status words that software reads over a simple 32-bit register port. The same port writes the enable, clear and configuration registers that drive the block's sideband outputs.

Each protection controller gets its own enable line and a one-cycle clear strobe. Each expansion security controller gets a held clear line and a held non-secure line. One combined interrupt is raised for the expansion security controller group only. Two configuration registers drive the response-mode and callable-region configuration outputs. Accesses that are not allowed, such as writes to status words, reads of write-only words and unmapped offsets, are ignored and flag an access error.

Reads and writes complete in one cycle. Read data and the error flag are registered and valid in the cycle after the access.

Top module: `sia_top`

## Requirements
- R1: The protection-controller status word at offset 0x020 holds internal controller k at bit k (k = 0, 1), expansion peripheral controller i at bit 4+i and expansion high-speed bus controller i at bit 20+i. Each bit follows its input level, sampled one clock earlier.
- R2: The memory-protection status word at offset 0x01C holds internal unit n at bit n and expansion unit n at bit 16+n. Each bit follows its input level.
- R3: The protection-controller enable register at offset 0x028 stores the written value ANDed with 0x00F000F3. Each controller's enable output equals that controller's status bit position in this register.
- R4: A write to offset 0x024 pulses the clear output of every protection controller whose status bit position is 1 in the written data. The pulse is high for exactly the one cycle after the write. Bits outside 0x00F000F3 have no effect.
- R5: The security-controller status word at offset 0x030 holds expansion controller n at bit 16+n. The enable register is at offset 0x038. The combined interrupt is high when any bit of status AND enable is set. It is registered from the stored status and enable, so it moves two cycles after an input change and one cycle after an enable write.
- R6: A write to offset 0x034 sets expansion controller n's clear output to bit 16+n of the data. A write to offset 0x03C sets its non-secure output to the same bit. Both outputs hold until the next write. Offset 0x03C reads back with the bits at 16+n.
- R7: The bridge status word at offset 0x040 always reads zero. The bridge enable register at offset 0x044 keeps only bits [31:16].
- R8: The callable configuration register at offset 0x000 keeps bits [1:0]. The response configuration register at offset 0x004 keeps all 32 bits. Each register drives its output directly.
- R9: Writes to the status words (0x01C, 0x020, 0x030, 0x040) leave all state unchanged and raise the access error. Reads of 0x024 or 0x034 return zero with the error. Any unmapped or misaligned offset also raises the error. Legal accesses leave the error low.
- R10: Reset clears all status, enable, clear and configuration state, so every output and the combined interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| acc_err | output | 1 | Access error, high the cycle after an illegal access |
| ppc_int_lvl | input | N_INT_PPC | Internal protection controller status levels |
| ppc_apbx_lvl | input | N_APBX | Expansion peripheral controller status levels |
| ppc_ahbx_lvl | input | N_AHBX | Expansion high-speed bus controller status levels |
| mpc_lvl | input | N_MPC | Internal memory protection status levels |
| mpcx_lvl | input | N_MPCX | Expansion memory protection status levels |
| mscx_lvl | input | N_MSCX | Expansion security controller status levels |
| ppc_int_en | output | N_INT_PPC | Internal controller interrupt enables |
| ppc_apbx_en | output | N_APBX | Expansion peripheral controller enables |
| ppc_ahbx_en | output | N_AHBX | Expansion high-speed bus controller enables |
| ppc_int_clr | output | N_INT_PPC | Internal controller clear strobes |
| ppc_apbx_clr | output | N_APBX | Expansion peripheral controller clear strobes |
| ppc_ahbx_clr | output | N_AHBX | Expansion high-speed bus controller clear strobes |
| mscx_clr | output | N_MSCX | Held clear lines for security controllers |
| mscx_ns | output | N_MSCX | Held non-secure lines for security controllers |
| msc_irq | output | 1 | Combined security controller interrupt |
| nsc_cfg | output | 2 | Callable configuration |
| resp_cfg | output | 32 | Response configuration |

## Verification
Register writes reach their outputs on the edge that takes the write, so enable, held-line and configuration outputs are sampled at the falling edge right after it. The clear strobes are sampled there and again one cycle later to show they fall. Status inputs need one edge to be captured and a second edge for the read, so the bench waits a cycle after changing a level before it reads. The combined interrupt is checked two falling edges after a status change and one after an enable write. The error flag and read data are sampled at the falling edge that follows the access.

// File: rtl/sia_pkg.sv
package sia_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [11:0] OFF_NSC     = 12'h000;
  localparam logic [11:0] OFF_RESP    = 12'h004;
  localparam logic [11:0] OFF_MPC_ST  = 12'h01C;
  localparam logic [11:0] OFF_PPC_ST  = 12'h020;
  localparam logic [11:0] OFF_PPC_CLR = 12'h024;
  localparam logic [11:0] OFF_PPC_EN  = 12'h028;
  localparam logic [11:0] OFF_MSC_ST  = 12'h030;
  localparam logic [11:0] OFF_MSC_CLR = 12'h034;
  localparam logic [11:0] OFF_MSC_EN  = 12'h038;
  localparam logic [11:0] OFF_MSC_NS  = 12'h03C;
  localparam logic [11:0] OFF_BRG_ST  = 12'h040;
  localparam logic [11:0] OFF_BRG_EN  = 12'h044;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic [11:0] off);
    case (off)
      OFF_NSC, OFF_RESP, OFF_PPC_EN,
      OFF_MSC_EN, OFF_MSC_NS, OFF_BRG_EN:     return ACC_RW;
      OFF_MPC_ST, OFF_PPC_ST,
      OFF_MSC_ST, OFF_BRG_ST:                 return ACC_RO;
      OFF_PPC_CLR, OFF_MSC_CLR:               return ACC_WO;
      default:                                return ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sia_field_capture.sv
module sia_field_capture #(
  parameter int unsigned N    = 1,
  parameter int unsigned BASE = 0,
  parameter int unsigned W    = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] placed;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g >= BASE && g < BASE + N) begin : g_src
      assign placed[g] = lvl_i[g-BASE];
    end else begin : g_zero
      assign placed[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= placed;
  end

endmodule

// File: rtl/sia_pulse_gen.sv
module sia_pulse_gen #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] pulse_o
);

  always_ff @(posedge clk) begin
    if (rst)        pulse_o <= '0;
    else if (stb_i) pulse_o <= bits_i;
    else            pulse_o <= '0;
  end

endmodule

// File: rtl/sia_top.sv
module sia_top #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned N_INT_PPC = 2,
  parameter int unsigned N_APBX    = 4,
  parameter int unsigned N_AHBX    = 4,
  parameter int unsigned N_MPC     = 2,
  parameter int unsigned N_MPCX    = 4,
  parameter int unsigned N_MSCX    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 acc_err,
  input  logic [N_INT_PPC-1:0] ppc_int_lvl,
  input  logic [N_APBX-1:0]    ppc_apbx_lvl,
  input  logic [N_AHBX-1:0]    ppc_ahbx_lvl,
  input  logic [N_MPC-1:0]     mpc_lvl,
  input  logic [N_MPCX-1:0]    mpcx_lvl,
  input  logic [N_MSCX-1:0]    mscx_lvl,
  output logic [N_INT_PPC-1:0] ppc_int_en,
  output logic [N_APBX-1:0]    ppc_apbx_en,
  output logic [N_AHBX-1:0]    ppc_ahbx_en,
  output logic [N_INT_PPC-1:0] ppc_int_clr,
  output logic [N_APBX-1:0]    ppc_apbx_clr,
  output logic [N_AHBX-1:0]    ppc_ahbx_clr,
  output logic [N_MSCX-1:0]    mscx_clr,
  output logic [N_MSCX-1:0]    mscx_ns,
  output logic                 msc_irq,
  output logic [1:0]           nsc_cfg,
  output logic [31:0]          resp_cfg
);
  import sia_pkg::*;

  localparam int unsigned APBX_BASE = 4;
  localparam int unsigned AHBX_BASE = 20;
  localparam int unsigned EXP_BASE  = 16;
  localparam int unsigned BRG_LO    = 16;
  localparam logic [REG_W-1:0] PPC_MASK =
      ((REG_W'(1) << N_INT_PPC) - 1) |
      (((REG_W'(1) << N_APBX) - 1) << APBX_BASE) |
      (((REG_W'(1) << N_AHBX) - 1) << AHBX_BASE);

  // access decode
  logic        in_range;
  acc_kind_e   kind;
  logic [11:0] off;

  assign in_range = ((addr >> 12) == '0);
  assign off      = addr[11:0];
  assign kind     = in_range ? classify(off) : ACC_NONE;

  logic wr_ok, rd_ok;
  assign wr_ok = wr_en && (kind == ACC_RW || kind == ACC_WO);
  assign rd_ok = rd_en && (kind == ACC_RW || kind == ACC_RO);

  // status capture
  logic [REG_W-1:0] ppc_int_w, ppc_apbx_w, ppc_ahbx_w;
  logic [REG_W-1:0] mpc_w, mpcx_w, msc_st;
  logic [REG_W-1:0] ppc_st, mpc_st;

  sia_field_capture #(.N(N_INT_PPC), .BASE(0), .W(REG_W)) i_cap_ppc_int (
    .clk(clk), .rst(rst), .lvl_i(ppc_int_lvl), .word_o(ppc_int_w));
  sia_field_capture #(.N(N_APBX), .BASE(APBX_BASE), .W(REG_W)) i_cap_ppc_apbx (
    .clk(clk), .rst(rst), .lvl_i(ppc_apbx_lvl), .word_o(ppc_apbx_w));
  sia_field_capture #(.N(N_AHBX), .BASE(AHBX_BASE), .W(REG_W)) i_cap_ppc_ahbx (
    .clk(clk), .rst(rst), .lvl_i(ppc_ahbx_lvl), .word_o(ppc_ahbx_w));
  sia_field_capture #(.N(N_MPC), .BASE(0), .W(REG_W)) i_cap_mpc (
    .clk(clk), .rst(rst), .lvl_i(mpc_lvl), .word_o(mpc_w));
  sia_field_capture #(.N(N_MPCX), .BASE(EXP_BASE), .W(REG_W)) i_cap_mpcx (
    .clk(clk), .rst(rst), .lvl_i(mpcx_lvl), .word_o(mpcx_w));
  sia_field_capture #(.N(N_MSCX), .BASE(EXP_BASE), .W(REG_W)) i_cap_msc (
    .clk(clk), .rst(rst), .lvl_i(mscx_lvl), .word_o(msc_st));

  assign ppc_st = ppc_int_w | ppc_apbx_w | ppc_ahbx_w;
  assign mpc_st = mpc_w | mpcx_w;

  // clear strobes for protection controllers
  logic [REG_W-1:0] ppc_clr_w;
  sia_pulse_gen #(.W(REG_W)) i_ppc_clr (
    .clk(clk), .rst(rst),
    .stb_i(wr_ok && off == OFF_PPC_CLR),
    .bits_i(wdata & PPC_MASK),
    .pulse_o(ppc_clr_w));

  // writable state
  logic [1:0]             nsc_q;
  logic [REG_W-1:0]       resp_q;
  logic [REG_W-1:0]       ppc_en_q;
  logic [REG_W-1:0]       msc_en_q;
  logic [N_MSCX-1:0]      mscx_clr_q;
  logic [N_MSCX-1:0]      mscx_ns_q;
  logic [REG_W-BRG_LO-1:0] brg_en_q;
  logic                   irq_q;
  logic                   err_q;
  logic [REG_W-1:0]       rdata_q;
  logic [REG_W-1:0]       rd_mux;

  always_comb begin
    rd_mux = '0;
    case (off)
      OFF_NSC:    rd_mux = {{(REG_W-2){1'b0}}, nsc_q};
      OFF_RESP:   rd_mux = resp_q;
      OFF_MPC_ST: rd_mux = mpc_st;
      OFF_PPC_ST: rd_mux = ppc_st;
      OFF_PPC_EN: rd_mux = ppc_en_q;
      OFF_MSC_ST: rd_mux = msc_st;
      OFF_MSC_EN: rd_mux = msc_en_q;
      OFF_MSC_NS: rd_mux = REG_W'(mscx_ns_q) << EXP_BASE;
      OFF_BRG_EN: rd_mux = {brg_en_q, {BRG_LO{1'b0}}};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nsc_q      <= '0;
      resp_q     <= '0;
      ppc_en_q   <= '0;
      msc_en_q   <= '0;
      mscx_clr_q <= '0;
      mscx_ns_q  <= '0;
      brg_en_q   <= '0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (wr_ok) begin
        case (off)
          OFF_NSC:     nsc_q      <= wdata[1:0];
          OFF_RESP:    resp_q     <= wdata;
          OFF_PPC_EN:  ppc_en_q   <= wdata & PPC_MASK;
          OFF_MSC_EN:  msc_en_q   <= wdata;
          OFF_MSC_CLR: mscx_clr_q <= wdata[EXP_BASE +: N_MSCX];
          OFF_MSC_NS:  mscx_ns_q  <= wdata[EXP_BASE +: N_MSCX];
          OFF_BRG_EN:  brg_en_q   <= wdata[REG_W-1:BRG_LO];
          default:     ;
        endcase
      end
      irq_q   <= |(msc_st & msc_en_q);
      err_q   <= (wr_en && !wr_ok) || (rd_en && !rd_ok);
      rdata_q <= rd_ok ? rd_mux : '0;
    end
  end

  assign rdata        = rdata_q;
  assign acc_err      = err_q;
  assign msc_irq      = irq_q;
  assign nsc_cfg      = nsc_q;
  assign resp_cfg     = resp_q;
  assign mscx_clr     = mscx_clr_q;
  assign mscx_ns      = mscx_ns_q;
  assign ppc_int_en   = ppc_en_q[0 +: N_INT_PPC];
  assign ppc_apbx_en  = ppc_en_q[APBX_BASE +: N_APBX];
  assign ppc_ahbx_en  = ppc_en_q[AHBX_BASE +: N_AHBX];
  assign ppc_int_clr  = ppc_clr_w[0 +: N_INT_PPC];
  assign ppc_apbx_clr = ppc_clr_w[APBX_BASE +: N_APBX];
  assign ppc_ahbx_clr = ppc_clr_w[AHBX_BASE +: N_AHBX];

endmodule

// File: rtl/sia_top_chk.sv
module sia_top_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned N_INT_PPC = 2,
  parameter int unsigned N_APBX    = 4,
  parameter int unsigned N_AHBX    = 4,
  parameter int unsigned N_MSCX    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          rdata,
  input logic                 acc_err,
  input logic [N_MSCX-1:0]    mscx_lvl,
  input logic [N_INT_PPC-1:0] ppc_int_en,
  input logic [N_APBX-1:0]    ppc_apbx_en,
  input logic [N_AHBX-1:0]    ppc_ahbx_en,
  input logic [N_INT_PPC-1:0] ppc_int_clr,
  input logic [N_APBX-1:0]    ppc_apbx_clr,
  input logic [N_AHBX-1:0]    ppc_ahbx_clr,
  input logic [N_MSCX-1:0]    mscx_clr,
  input logic                 msc_irq
);
  import sia_pkg::*;

  logic at_ppc_clr, at_ppc_en, at_ppc_st, at_brg_st, at_msc_clr;
  assign at_ppc_clr = (addr == ADDR_W'(OFF_PPC_CLR));
  assign at_ppc_en  = (addr == ADDR_W'(OFF_PPC_EN));
  assign at_ppc_st  = (addr == ADDR_W'(OFF_PPC_ST));
  assign at_brg_st  = (addr == ADDR_W'(OFF_BRG_ST));
  assign at_msc_clr = (addr == ADDR_W'(OFF_MSC_CLR));

  assert_clr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (|{ppc_int_clr, ppc_apbx_clr, ppc_ahbx_clr}) |-> $past(wr_en && at_ppc_clr));

  assert_en_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && at_ppc_en) |-> $stable({ppc_int_en, ppc_apbx_en, ppc_ahbx_en}));

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(mscx_lvl) == '0 && $past(mscx_lvl, 2) == '0) |-> !msc_irq);

  assert_mscclr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && at_msc_clr) |-> $stable(mscx_clr));

  assert_brg_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && at_brg_st) |-> (rdata == '0));

  assert_ro_err_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && at_ppc_st) |=> acc_err);

endmodule

bind sia_top sia_top_chk #(
  .ADDR_W(ADDR_W), .N_INT_PPC(N_INT_PPC), .N_APBX(N_APBX),
  .N_AHBX(N_AHBX), .N_MSCX(N_MSCX)
) i_sia_top_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .acc_err(acc_err), .mscx_lvl(mscx_lvl),
  .ppc_int_en(ppc_int_en), .ppc_apbx_en(ppc_apbx_en), .ppc_ahbx_en(ppc_ahbx_en),
  .ppc_int_clr(ppc_int_clr), .ppc_apbx_clr(ppc_apbx_clr),
  .ppc_ahbx_clr(ppc_ahbx_clr), .mscx_clr(mscx_clr), .msc_irq(msc_irq)
);

// File: tb/test_sia_top.sv
module test_sia_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [11:0] A_NSC = 12'h000, A_RESP = 12'h004, A_MPC_ST = 12'h01C,
                          A_PPC_ST = 12'h020, A_PPC_CLR = 12'h024, A_PPC_EN = 12'h028,
                          A_MSC_ST = 12'h030, A_MSC_CLR = 12'h034, A_MSC_EN = 12'h038,
                          A_MSC_NS = 12'h03C, A_BRG_ST = 12'h040, A_BRG_EN = 12'h044;

  // {addr, write data, expected read-back}
  localparam int NVEC = 11;
  localparam logic [75:0] VEC [NVEC] = '{
    {A_PPC_EN, 32'hFFFF_FFFF, 32'h00F0_00F3},
    {A_PPC_EN, 32'h1234_5678, 32'h0030_0070},
    {A_BRG_EN, 32'hFFFF_FFFF, 32'hFFFF_0000},
    {A_BRG_EN, 32'h0000_ABCD, 32'h0000_0000},
    {A_NSC,    32'hFFFF_FFFF, 32'h0000_0003},
    {A_NSC,    32'h0000_0006, 32'h0000_0002},
    {A_RESP,   32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {A_MSC_EN, 32'h000F_0000, 32'h000F_0000},
    {A_MSC_NS, 32'hFFFF_FFFF, 32'h000F_0000},
    {A_MSC_NS, 32'h0005_0000, 32'h0005_0000},
    {A_RESP,   32'h0000_0000, 32'h0000_0000}
  };
  localparam string VTAG [NVEC] = '{"R3", "R3", "R7", "R7", "R8", "R8", "R8",
                                    "R5", "R6", "R6", "R8"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic acc_err;
  logic [1:0] ppc_int_lvl = '0;
  logic [3:0] ppc_apbx_lvl = '0, ppc_ahbx_lvl = '0;
  logic [1:0] mpc_lvl = '0;
  logic [3:0] mpcx_lvl = '0, mscx_lvl = '0;
  logic [1:0] ppc_int_en, ppc_int_clr, nsc_cfg;
  logic [3:0] ppc_apbx_en, ppc_ahbx_en, ppc_apbx_clr, ppc_ahbx_clr, mscx_clr, mscx_ns;
  logic msc_irq;
  logic [31:0] resp_cfg;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sia_top i_sia_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .acc_err(acc_err),
    .ppc_int_lvl(ppc_int_lvl), .ppc_apbx_lvl(ppc_apbx_lvl), .ppc_ahbx_lvl(ppc_ahbx_lvl),
    .mpc_lvl(mpc_lvl), .mpcx_lvl(mpcx_lvl), .mscx_lvl(mscx_lvl),
    .ppc_int_en(ppc_int_en), .ppc_apbx_en(ppc_apbx_en), .ppc_ahbx_en(ppc_ahbx_en),
    .ppc_int_clr(ppc_int_clr), .ppc_apbx_clr(ppc_apbx_clr), .ppc_ahbx_clr(ppc_ahbx_clr),
    .mscx_clr(mscx_clr), .mscx_ns(mscx_ns), .msc_irq(msc_irq),
    .nsc_cfg(nsc_cfg), .resp_cfg(resp_cfg));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata; e = acc_err;
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R10: reset state
    chk("R10 enables", {26'd0, ppc_int_en, ppc_apbx_en}, 32'd0);
    chk("R10 cfg", {30'd0, nsc_cfg} | resp_cfg, 32'd0);
    chk("R10 irq/clr", {27'd0, msc_irq, mscx_clr}, 32'd0);
    rd(A_PPC_EN, d, e);
    chk("R10 enable reg", d, 32'd0);

    // vector table: write then read back
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      chk({VTAG[i], " write err"}, {31'd0, acc_err}, 32'd0);
      rd(VEC[i][75:64], d, e);
      chk({VTAG[i], " readback"}, d, VEC[i][31:0]);
    end
    chk("R8 nsc_cfg out", {30'd0, nsc_cfg}, 32'd2);

    // R3: enable outputs
    wr(A_PPC_EN, 32'h0010_0021);
    chk("R3 int_en", {30'd0, ppc_int_en}, 32'd1);
    chk("R3 apbx_en", {28'd0, ppc_apbx_en}, 32'd2);
    chk("R3 ahbx_en", {28'd0, ppc_ahbx_en}, 32'd1);

    // R1: status placement and level following
    ppc_int_lvl = 2'b10; ppc_apbx_lvl = 4'b0101; ppc_ahbx_lvl = 4'b1000;
    step();
    rd(A_PPC_ST, d, e);
    chk("R1 sparse", d, 32'h0080_0052);
    ppc_int_lvl = 2'b11; ppc_apbx_lvl = 4'hF; ppc_ahbx_lvl = 4'hF;
    step();
    rd(A_PPC_ST, d, e);
    chk("R1 all", d, 32'h00F0_00F3);
    ppc_int_lvl = '0; ppc_apbx_lvl = '0; ppc_ahbx_lvl = '0;
    step();
    rd(A_PPC_ST, d, e);
    chk("R1 cleared", d, 32'h0);

    // R2: memory protection status
    mpc_lvl = 2'b01; mpcx_lvl = 4'b1010;
    step();
    rd(A_MPC_ST, d, e);
    chk("R2 status", d, 32'h000A_0001);

    // R5: combined interrupt
    wr(A_MSC_EN, 32'h0002_0000);
    mscx_lvl = 4'b0001;
    step(); step();
    chk("R5 masked irq", {31'd0, msc_irq}, 32'd0);
    rd(A_MSC_ST, d, e);
    chk("R5 status", d, 32'h0001_0000);
    mscx_lvl = 4'b0011;
    step(); step();
    chk("R5 irq high", {31'd0, msc_irq}, 32'd1);
    wr(A_MSC_EN, 32'h0);
    step();
    chk("R5 irq drop on disable", {31'd0, msc_irq}, 32'd0);
    mscx_lvl = '0;

    // R6: held clear and non-secure lines
    wr(A_MSC_CLR, 32'h000C_0001);
    chk("R6 clr", {28'd0, mscx_clr}, 32'hC);
    step(); step();
    chk("R6 clr held", {28'd0, mscx_clr}, 32'hC);
    wr(A_MSC_NS, 32'h0003_0000);
    chk("R6 ns", {28'd0, mscx_ns}, 32'h3);

    // R4: protection controller clear strobes
    wr(A_PPC_CLR, 32'h0010_0012);
    chk("R4 pulse", {22'd0, ppc_int_clr, ppc_apbx_clr, ppc_ahbx_clr}, 32'b10_0001_0001);
    step();
    chk("R4 pulse ends", {22'd0, ppc_int_clr, ppc_apbx_clr, ppc_ahbx_clr}, 32'd0);
    wr(A_PPC_CLR, 32'hFF0F_FF0C);
    chk("R4 unmasked bits", {22'd0, ppc_int_clr, ppc_apbx_clr, ppc_ahbx_clr}, 32'd0);

    // R9 and R7: illegal accesses
    wr(A_MPC_ST, 32'hFFFF_FFFF);
    chk("R9 ro write err", {31'd0, acc_err}, 32'd1);
    rd(A_MPC_ST, d, e);
    chk("R9 ro unchanged", d, 32'h000A_0001);
    wr(A_BRG_ST, 32'hFFFF_FFFF);
    chk("R9 brg write err", {31'd0, acc_err}, 32'd1);
    rd(A_BRG_ST, d, e);
    chk("R7 brg zero", d, 32'd0);
    rd(A_PPC_CLR, d, e);
    chk("R9 wo read err", {31'd0, e}, 32'd1);
    chk("R9 wo read data", d, 32'd0);
    wr(12'h100, 32'h1);
    chk("R9 unmapped err", {31'd0, acc_err}, 32'd1);
    wr(12'h022, 32'h1);
    chk("R9 misaligned err", {31'd0, acc_err}, 32'd1);
    rd(A_RESP, d, e);
    chk("R9 legal no err", {31'd0, e}, 32'd0);

    // R10: reset mid-run
    wr(A_MSC_EN, 32'h000F_0000);
    wr(A_NSC, 32'h3);
    mscx_lvl = 4'b0100;
    step(); step();
    chk("R10 pre irq", {31'd0, msc_irq}, 32'd1);
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    chk("R10 irq low", {31'd0, msc_irq}, 32'd0);
    chk("R10 outs clear", {22'd0, nsc_cfg, mscx_clr, mscx_ns}, 32'd0);
    mscx_lvl = '0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule